// File: doc/BRIEF.md
# Complementary Dead-Time Insertion Unit

This block sits between a three-phase PWM source and the gate drivers of a six-switch inverter. For each of the six switches (upper and lower for phases U, V and W) it takes the internal on/off request and produces a gate turn-on signal. It holds back every off-to-on transition by a programmable dead time, so that the complementary transistor in the same leg has finished turning off before its partner turns on. On-to-off transitions pass with no added delay.

The dead time is a count `n` in units of a selectable count source: either the base clock or a half-rate tick derived from it. A single prescaler serves all six channels. Each channel has its own down-counter. The count is captured when a turn-on begins, so changing it later does not disturb a delay that is already running. An active-low insertion control selects the mode. When it is low, dead time is inserted. When it is high, the requests pass straight through to the registered outputs.

Top module: `dtu_top`

## Requirements
- R1: While reset is high, and on the first edge after it, all six outputs are 0.
- R2: With `dt_bypass_n` = 1, each output equals its request as sampled at the previous clock edge.
- R3: When a request is 0 at a clock edge, the matching output is 0 after that edge, in every mode.
- R4: With insertion active, `src_half` = 0 and `dt_count` = n ≥ 1, a request that rises and stays high drives its output to 1 after exactly n+1 edges, counting the first edge that samples the request high as edge 1.
- R5: With `src_half` = 1, the half-rate source ticks on the 2nd, 4th, 6th, … edge after reset is released. An output then rises on the edge that carries the n-th tick after the first high sample, which is n·2 or n·2+1 edges after that first sample (the first sample counted as edge 1).
- R6: A count of n = 0 inserts no delay. The output rises after the first edge that samples the request high.
- R7: A request that falls before its dead time expires never reaches the output, and the next rise restarts the full dead time.
- R8: `dt_count` is captured on the edge that starts a turn-on. Later changes to it do not alter a countdown that is already running.
- R9: The six channels are independent. Bit 0/1 are the U upper/lower switches, bit 2/3 the V upper/lower, and bit 4/5 the W upper/lower. The half-rate tick is shared by all six.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_req | input | 6 | Internal on requests, one per switch |
| dt_count | input | 8 | Dead-time count n |
| src_half | input | 1 | 0: count on every base clock, 1: count on the half-rate tick |
| dt_bypass_n | input | 1 | 0: insert dead time, 1: pass requests through |
| gate_on | output | 6 | Delayed turn-on signals, registered |

## Verification
Every output is registered. A fall or a bypassed change is therefore due one edge after it is sampled, and a turn-on is due n+1 edges after it is sampled (full rate) or n·2 to n·2+1 edges after it (half rate). The bench drives its inputs on falling edges and compares on falling edges. Each comparison sees exactly the edges counted in the requirement. A reference model updated on each rising edge predicts all six outputs every cycle, including the phase of the half-rate tick counted from reset. Directed measurements count the edges from the stimulus to the rise and check the count against the number the requirement gives.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int PHASES        = 3;
  localparam int SW_PER_PHASE  = 2;
  localparam int NUM_SW        = PHASES * SW_PER_PHASE;
  localparam int CNT_W         = 8;

  typedef enum logic {
    SRC_FULL = 1'b0,
    SRC_HALF = 1'b1
  } src_sel_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_ON   = 2'd2
  } ch_state_e;
endpackage

// File: rtl/dtu_prescale.sv
module dtu_prescale (
  input  logic clk,
  input  logic rst,
  output logic half_tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= ~phase_q;
  end

  assign half_tick = phase_q;

  // R5: ticks never land on two edges in a row
  a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          bypass,
  input  logic          cnt_tick,
  input  logic [CW-1:0] load_val,
  output logic          gate
);
  ch_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      gate_q <= 1'b0;
    end else if (bypass) begin
      gate_q <= req;
      st_q   <= req ? CH_ON : CH_IDLE;
      cnt_q  <= '0;
    end else if (!req) begin
      gate_q <= 1'b0;
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE: begin
          if (load_val == '0) begin
            gate_q <= 1'b1;
            st_q   <= CH_ON;
          end else begin
            cnt_q <= load_val;
            st_q  <= CH_WAIT;
          end
        end
        CH_WAIT: begin
          if (cnt_tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) begin
              gate_q <= 1'b1;
              st_q   <= CH_ON;
            end
          end
        end
        default: begin
          gate_q <= 1'b1;
          st_q   <= CH_ON;
        end
      endcase
    end
  end

  assign gate = gate_q;

  // R3: a low request always forces the gate off at the next edge
  a_r3_off_fast: assert property (@(posedge clk) disable iff (rst)
    !req |=> !gate);
  // R2: bypass mirrors the request with one register of latency
  a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (gate == $past(req)));
  // R6: zero count turns on at the first sampled edge
  a_r6_zero_dt: assert property (@(posedge clk) disable iff (rst)
    (!bypass && req && st_q == CH_IDLE && load_val == '0) |=> gate);
  // R4: no early turn-on while more than one tick remains
  a_r4_no_early: assert property (@(posedge clk) disable iff (rst)
    (!bypass && st_q == CH_WAIT && cnt_q > 1) |=> !gate);
  // R8: a running countdown moves only on ticks
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!bypass && req && st_q == CH_WAIT && !cnt_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/dtu_top.sv
module dtu_top
  import dtu_pkg::*;
#(
  parameter int NSW = NUM_SW,
  parameter int CW  = CNT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NSW-1:0] phase_req,
  input  logic [CW-1:0]  dt_count,
  input  logic           src_half,
  input  logic           dt_bypass_n,
  output logic [NSW-1:0] gate_on
);
  logic half_tick;
  logic cnt_tick;
  logic bypass;

  dtu_prescale u_pre (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick)
  );

  assign cnt_tick = (src_sel_e'(src_half) == SRC_HALF) ? half_tick : 1'b1;
  assign bypass   = dt_bypass_n;

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    dtu_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .req      (phase_req[g]),
      .bypass   (bypass),
      .cnt_tick (cnt_tick),
      .load_val (dt_count),
      .gate     (gate_on[g])
    );
  end

  // R1: reset leaves every output off
  a_r1_reset_off: assert property (@(posedge clk)
    rst |=> (gate_on == '0));
  // R9: no output turns on unless its own request was high
  a_r9_own_req: assert property (@(posedge clk) disable iff (rst)
    ((gate_on & ~$past(phase_req)) == '0) || $past(rst));
endmodule

// File: tb/sim_dtu_top.sv
module sim_dtu_top;
  localparam int NSW = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NSW-1:0] phase_req = '0;
  logic [7:0]     dt_count = '0;
  logic           src_half = 1'b0;
  logic           dt_bypass_n = 1'b0;
  logic [NSW-1:0] gate_on;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dtu_top u0 (
    .clk(clk), .rst(rst), .phase_req(phase_req), .dt_count(dt_count),
    .src_half(src_half), .dt_bypass_n(dt_bypass_n), .gate_on(gate_on)
  );

  // reference model built from the requirements
  logic [NSW-1:0] m_out = '0;
  logic [NSW-1:0] m_arm = '0;
  int             m_cnt [NSW];
  int             edges_since_rst = 0;

  always @(posedge clk) begin
    logic tk;
    if (rst) begin
      m_out = '0; m_arm = '0; edges_since_rst = 0;
      for (int i = 0; i < NSW; i++) m_cnt[i] = 0;
    end else begin
      edges_since_rst++;
      tk = src_half ? ((edges_since_rst % 2) == 0) : 1'b1;   // R5 tick phase
      for (int i = 0; i < NSW; i++) begin
        if (dt_bypass_n) begin
          m_out[i] = phase_req[i]; m_arm[i] = 1'b0;
        end else if (!phase_req[i]) begin
          m_out[i] = 1'b0; m_arm[i] = 1'b0;
        end else if (!m_out[i]) begin
          if (!m_arm[i]) begin
            if (dt_count == 0) m_out[i] = 1'b1;
            else begin m_arm[i] = 1'b1; m_cnt[i] = int'(dt_count); end
          end else if (tk) begin
            m_cnt[i]--;
            if (m_cnt[i] == 0) begin m_out[i] = 1'b1; m_arm[i] = 1'b0; end
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // wait for the next falling edge and compare every channel with the model
  task automatic step();
    string tag;
    @(negedge clk);
    for (int i = 0; i < NSW; i++) begin
      if (rst) tag = "R1";
      else if (dt_bypass_n) tag = "R2";
      else if (!phase_req[i]) tag = "R3";
      else if (src_half) tag = "R5";
      else tag = "R4";
      check($sformatf("%s ch%0d", tag, i), int'(gate_on[i]), int'(m_out[i]));
    end
  endtask

  task automatic idle(input int cyc);
    phase_req = '0;
    for (int k = 0; k < cyc; k++) step();
  endtask

  // raise one request and count edges until its output rises
  task automatic measure(input string tag, input int ch, input int n, input bit half,
                         input bit byp, input int lo, input int hi,
                         input int chg_at, input int chg_n);
    int k;
    dt_count = 8'(n); src_half = half; dt_bypass_n = byp;
    idle(3);
    phase_req[ch] = 1'b1;
    k = 0;
    while (!gate_on[ch] && k < 600) begin
      step(); k++;
      if (k == chg_at) dt_count = 8'(chg_n);
    end
    n_cmp++;
    if (k < lo || k > hi) begin
      n_bad++;
      $display("FAIL %s edges actual=%0d expected=%0d..%0d", tag, k, lo, hi);
    end
    idle(2);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    repeat (3) step();
    check("R1 reset outputs", int'(gate_on), 0);
    rst = 1'b0;
    step();
    check("R1 first edge after reset", int'(gate_on), 0);

    measure("R4 n=5", 0, 5, 1'b0, 1'b0, 6, 6, 0, 0);
    measure("R4 n=1", 3, 1, 1'b0, 1'b0, 2, 2, 0, 0);
    measure("R6 n=0", 1, 0, 1'b0, 1'b0, 1, 1, 0, 0);
    measure("R2 bypass", 4, 20, 1'b0, 1'b1, 1, 1, 0, 0);
    measure("R5 n=4 half", 5, 4, 1'b1, 1'b0, 8, 9, 0, 0);
    measure("R5 n=7 half", 2, 7, 1'b1, 1'b0, 14, 15, 0, 0);
    measure("R8 count change ignored", 0, 8, 1'b0, 1'b0, 9, 9, 2, 2);

    // R3: turn-off passes with one edge of latency
    dt_bypass_n = 1'b0; src_half = 1'b0; dt_count = 8'd2;
    phase_req = 6'b111111;
    repeat (6) step();
    check("R3 all on before drop", int'(gate_on), 63);
    phase_req = '0;
    step();
    check("R3 off after one edge", int'(gate_on), 0);

    // R7: a short pulse is swallowed, then the full delay restarts
    dt_count = 8'd10;
    phase_req[2] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R7 short pulse held off", int'(gate_on[2]), 0);
    end
    phase_req[2] = 1'b0;
    step(); step();
    check("R7 stays off after drop", int'(gate_on[2]), 0);
    measure("R7 full restart", 2, 10, 1'b0, 1'b0, 11, 11, 0, 0);

    // R9: independent channels, mixed random stimulus
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NSW; i++)
        if ($urandom_range(0, 11) == 0) phase_req[i] = ~phase_req[i];
      if ($urandom_range(0, 39) == 0) dt_count = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 199) == 0) src_half = ~src_half;
      if ($urandom_range(0, 299) == 0) dt_bypass_n = ~dt_bypass_n;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule